// File: doc/BRIEF.md
# Masked Fault Latch Register

This block keeps an 8-bit record of supply faults. Each bit is active-low: it reads 1 while healthy and drops to 0 when its fault is seen. Once a bit has dropped it stays at 0 after the fault goes away. The inputs are comparator flags that have already been digitized. They cover under- and overvoltage on three rails, an overload flag and a converter malfunction flag. Each flag passes through a synchronizer before it is latched. A separate set of injection inputs lets a self-test sequencer force faults straight into the latch.

An 8-bit reporting mask selects which latched faults are reported. The active-low indicator `fail_n_o` goes low while any latched bit that is enabled in the mask is at 0. It also goes low while a self-test result holds a failure that is enabled for reporting. A hold timer restores the reported bits to 1. It runs after every reported fault has cleared and while the idle input has stayed high the whole time. Bits with mask 0 are never restored by the timer.

A capture strobe copies the register into a snapshot for a serial reporter. The snapshot leaves through a valid/ready port. While `snap_valid_o` is high and `snap_ready_i` is low, the data holds steady and further capture strobes are ignored. A transfer completes on a cycle where valid and ready are both high. A capture strobe in that same cycle loads a new snapshot.

Top module: `fault_latch_reg`

## Requirements
- R1: After reset the register and the mask are all ones, `fail_n_o` is 1 and `snap_valid_o` is 0.
- R2: A raw fault flag `fault_i[i]`=1 clears register bit i at the third rising edge after it is applied, through two synchronizer stages. The bit stays 0 after the flag drops, until the timer restores it.
- R3: An injection flag `inject_i[i]`=1 clears register bit i at the next rising edge, with no synchronizer delay.
- R4: `fail_n_o` is 0 exactly when some register bit is 0 while its mask bit is 1, or when the self-test failure flag is set. Cleared bits with mask 0 do not pull it low.
- R5: Call an edge a restart edge when, at that edge, a reported fault is active (synchronized or injected, with mask bit 1), or `idle_i` is 0, or the mask is written. HOLD_CYCLES edges after the last restart edge, the register bits whose mask bit is 1 are set back to 1. Bits with mask bit 0 keep their value.
- R6: `mask_we_i`=1 loads `mask_wdata_i` into the mask at the rising edge. A mask bit of 1 means the fault is reported.
- R7: `st_done_i`=1 sets the self-test failure flag when `st_result_i` (active-low) has a 0 in any bit whose mask bit is 1, and clears the flag otherwise. `st_begin_i`=1 clears the flag and takes priority.
- R8: When `snap_req_i`=1 and the port is free (`snap_valid_o`=0 or `snap_ready_i`=1), the register value from before that edge is loaded into `snap_data_o` and `snap_valid_o` becomes 1. Otherwise, when `snap_ready_i`=1, `snap_valid_o` becomes 0. While valid is high and ready is low, the data holds.
- R9: Bit map: bit0/bit1 are rail 1 under/over, bit2/bit3 are rail 2 under/over, bit4/bit5 are rail 3 under/over, bit6 is overload and bit7 is converter malfunction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 8 | Raw fault flags, 1 = fault present |
| inject_i | input | 8 | Self-test fault injection, 1 = force fault |
| idle_i | input | 1 | Idle state; 0 holds off restore |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | New mask value |
| st_begin_i | input | 1 | Self test starts; clears failure flag |
| st_done_i | input | 1 | Self-test result valid |
| st_result_i | input | 8 | Self-test result, active-low per bit |
| snap_req_i | input | 1 | Capture strobe |
| snap_valid_o | output | 1 | Snapshot valid |
| snap_ready_i | input | 1 | Snapshot consumer ready |
| snap_data_o | output | 8 | Snapshot contents |
| fault_reg_o | output | 8 | Live fault register |
| fail_n_o | output | 1 | Active-low failure indicator |

## Verification
The assertions assume a clean reset and inputs that are stable around each rising edge. They make no assumption about the timing of `fault_i` relative to the clock, because the synchronizer absorbs it. The snapshot hold check assumes the consumer may keep ready low for as long as it likes, and the bench drives ready at random to cover that. Random fault flags are rare and idle is mostly high, so the hold timer regularly expires and restores take place between bursts.

// File: rtl/fault_latch_pkg.sv
package fault_latch_pkg;
  localparam int FLT_W = 8;
  typedef logic [FLT_W-1:0] flt_vec_t;
  typedef enum int {
    RAIL1_UNDER = 0, RAIL1_OVER = 1,
    RAIL2_UNDER = 2, RAIL2_OVER = 3,
    RAIL3_UNDER = 4, RAIL3_OVER = 5,
    OVERLOAD    = 6, MALFUNCTION = 7
  } flt_bit_e;
endpackage

// File: rtl/flr_sync.sv
module flr_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else if (g == 0) stg[g] <= d_i;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/flr_hold_timer.sv
module flr_hold_timer #(
  parameter int HOLD_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic release_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
  localparam logic [CW-1:0] DONE = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (restart_i) cnt <= '0;
    else if (cnt != DONE) cnt <= cnt + 1'b1;
  end

  assign release_o = !restart_i && (cnt == LAST);

  // R5: counter saturates at the hold length
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= DONE);
  // R5: one release per quiet period
  a_r5_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> !release_o);
endmodule

// File: rtl/flr_snapshot.sv
module flr_snapshot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  logic load;
  assign load = req_i && (!valid_o || ready_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '1;
    end else if (load) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R8: a stalled snapshot keeps its data
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/fault_latch_reg.sv
module fault_latch_reg
  import fault_latch_pkg::*;
#(
  parameter int HOLD_CYCLES = 2500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLT_W-1:0] fault_i,
  input  logic [FLT_W-1:0] inject_i,
  input  logic             idle_i,
  input  logic             mask_we_i,
  input  logic [FLT_W-1:0] mask_wdata_i,
  input  logic             st_begin_i,
  input  logic             st_done_i,
  input  logic [FLT_W-1:0] st_result_i,
  input  logic             snap_req_i,
  output logic             snap_valid_o,
  input  logic             snap_ready_i,
  output logic [FLT_W-1:0] snap_data_o,
  output logic [FLT_W-1:0] fault_reg_o,
  output logic             fail_n_o
);
  flt_vec_t fault_sync, fault_act, fault_reg, mask, restore;
  logic     rep_active, restart, release_now, st_fail, started;

  flr_sync #(.W(FLT_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(fault_i), .q_o(fault_sync));

  assign fault_act  = fault_sync | inject_i;
  assign rep_active = |(fault_act & mask);
  assign restart    = rep_active || !idle_i || mask_we_i;

  flr_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .release_o(release_now));

  assign restore = release_now ? mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_reg <= '1;
      mask      <= '1;
      st_fail   <= 1'b0;
      started   <= 1'b0;
    end else begin
      started   <= 1'b1;
      fault_reg <= (fault_reg | restore) & ~fault_act;
      if (mask_we_i) mask <= mask_wdata_i;
      if (st_begin_i) st_fail <= 1'b0;
      else if (st_done_i) st_fail <= |(~st_result_i & mask);
    end
  end

  flr_snapshot #(.W(FLT_W)) i_snap (
    .clk(clk), .rst_n(rst_n), .req_i(snap_req_i), .data_i(fault_reg),
    .valid_o(snap_valid_o), .ready_i(snap_ready_i), .data_o(snap_data_o));

  assign fault_reg_o = fault_reg;
  assign fail_n_o    = !(|(~fault_reg & mask) || st_fail);

  // R2/R3: an active fault leaves its bit at 0 after the edge
  a_r2_active_clears: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> ((fault_reg & $past(fault_act)) == '0));
  // R5: a bit only rises on a release, and only where the mask reports
  a_r5_rise_only_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> ((~$past(fault_reg) & fault_reg &
                  ~($past(release_now) ? $past(mask) : '0)) == '0));
  // R5: no release while a reported fault is still present
  a_r5_no_release_active: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |-> !rep_active);
  // R7: starting a self test drops the self-test failure flag
  a_r7_begin_clears: assert property (@(posedge clk) disable iff (!rst_n)
    st_begin_i |=> !st_fail);
endmodule

// File: tb/test_fault_latch_reg.sv
module test_fault_latch_reg;
  localparam int HOLD = 20;
  logic clk = 0, rst_n = 0;
  logic [7:0] fault_i = 0, inject_i = 0, mask_wdata_i = 0, st_result_i = 8'hFF;
  logic idle_i = 1, mask_we_i = 0, st_begin_i = 0, st_done_i = 0;
  logic snap_req_i = 0, snap_ready_i = 0;
  logic snap_valid_o, fail_n_o;
  logic [7:0] snap_data_o, fault_reg_o;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  fault_latch_reg #(.HOLD_CYCLES(HOLD)) i_fault_latch_reg (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .inject_i(inject_i),
    .idle_i(idle_i), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .st_begin_i(st_begin_i), .st_done_i(st_done_i), .st_result_i(st_result_i),
    .snap_req_i(snap_req_i), .snap_valid_o(snap_valid_o),
    .snap_ready_i(snap_ready_i), .snap_data_o(snap_data_o),
    .fault_reg_o(fault_reg_o), .fail_n_o(fail_n_o));

  // reference state built from the requirements
  logic [7:0] m_s1 = 0, m_s2 = 0, m_reg = 8'hFF, m_mask = 8'hFF, m_snap = 8'hFF;
  logic m_sv = 0, m_st = 0;
  int m_cnt = 0;

  function automatic logic exp_fail_n(logic [7:0] r, logic [7:0] m, logic st);
    return !(|(~r & m) || st);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      logic [7:0] act;
      logic rst_evt, rel;
      act = m_s2 | inject_i;
      rst_evt = |(act & m_mask) || !idle_i || mask_we_i;   // R5 restart edge
      rel = !rst_evt && (m_cnt == HOLD - 1);
      if (snap_req_i && (!m_sv || snap_ready_i)) begin m_snap = m_reg; m_sv = 1; end
      else if (snap_ready_i) m_sv = 0;
      if (st_begin_i) m_st = 0;
      else if (st_done_i) m_st = |(~st_result_i & m_mask);
      m_reg = (m_reg | (rel ? m_mask : 8'h00)) & ~act;
      if (mask_we_i) m_mask = mask_wdata_i;
      m_cnt = rst_evt ? 0 : (m_cnt < HOLD ? m_cnt + 1 : m_cnt);
      m_s2 = m_s1; m_s1 = fault_i;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) if (rst_n) begin
    check(fault_reg_o == m_reg, "R2/R3/R5 register", fault_reg_o, m_reg);
    check(fail_n_o == exp_fail_n(m_reg, m_mask, m_st), "R4/R7 indicator",
          {7'd0, fail_n_o}, {7'd0, exp_fail_n(m_reg, m_mask, m_st)});
    check(snap_valid_o == m_sv, "R8 valid", {7'd0, snap_valid_o}, {7'd0, m_sv});
    if (m_sv) check(snap_data_o == m_snap, "R8 data", snap_data_o, m_snap);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    // R1 reset state
    check(fault_reg_o == 8'hFF, "R1 register", fault_reg_o, 8'hFF);
    check(fail_n_o == 1'b1, "R1 indicator", {7'd0, fail_n_o}, 8'h01);
    check(snap_valid_o == 1'b0, "R1 snapshot valid", {7'd0, snap_valid_o}, 8'h00);

    // R3/R9: inject overload (bit6), cleared after one edge
    inject_i = 8'h40; step(1);
    check(fault_reg_o == 8'hBF, "R3 R9 overload bit", fault_reg_o, 8'hBF);
    check(fail_n_o == 1'b0, "R4 indicator low", {7'd0, fail_n_o}, 8'h00);
    inject_i = 8'h00;
    // R5: restored exactly HOLD edges after the last restart edge
    step(HOLD - 1);
    check(fault_reg_o == 8'hBF, "R5 not yet restored", fault_reg_o, 8'hBF);
    step(1);
    check(fault_reg_o == 8'hFF, "R5 restored", fault_reg_o, 8'hFF);

    // R2: rail 1 undervoltage through the synchronizer
    fault_i = 8'h01; step(2);
    check(fault_reg_o == 8'hFF, "R2 before sync", fault_reg_o, 8'hFF);
    step(1);
    check(fault_reg_o == 8'hFE, "R2 after sync", fault_reg_o, 8'hFE);
    fault_i = 8'h00; step(HOLD + 4);

    // R6/R4/R5: malfunction (bit7) unreported never restores, indicator stays high
    mask_wdata_i = 8'h7F; mask_we_i = 1; step(1); mask_we_i = 0;
    inject_i = 8'h80; step(1); inject_i = 0;
    check(fail_n_o == 1'b1, "R4 unreported ignored", {7'd0, fail_n_o}, 8'h01);
    step(3 * HOLD);
    check(fault_reg_o == 8'h7F, "R5 unreported kept", fault_reg_o, 8'h7F);
    mask_wdata_i = 8'hFF; mask_we_i = 1; step(1); mask_we_i = 0;
    check(fail_n_o == 1'b0, "R6 mask enables report", {7'd0, fail_n_o}, 8'h00);
    // R5: idle low holds off restore
    idle_i = 0; step(3 * HOLD);
    check(fault_reg_o == 8'h7F, "R5 idle low holds", fault_reg_o, 8'h7F);
    idle_i = 1; step(HOLD + 1);
    check(fault_reg_o == 8'hFF, "R5 restore after idle", fault_reg_o, 8'hFF);

    // R7: self-test failure sticks until next begin
    st_result_i = 8'hEF; st_done_i = 1; step(1); st_done_i = 0; st_result_i = 8'hFF;
    step(3 * HOLD);
    check(fail_n_o == 1'b0, "R7 sticky failure", {7'd0, fail_n_o}, 8'h00);
    st_begin_i = 1; step(1); st_begin_i = 0;
    check(fail_n_o == 1'b1, "R7 cleared on begin", {7'd0, fail_n_o}, 8'h01);

    // R8: snapshot under back-pressure
    inject_i = 8'h05; step(1); inject_i = 0;
    snap_req_i = 1; step(1); snap_req_i = 0;
    check(snap_valid_o && snap_data_o == 8'hFA, "R8 capture", snap_data_o, 8'hFA);
    step(HOLD + 2);
    snap_req_i = 1; step(1); snap_req_i = 0;
    check(snap_data_o == 8'hFA, "R8 held while stalled", snap_data_o, 8'hFA);
    snap_ready_i = 1; step(1); snap_ready_i = 0;
    check(snap_valid_o == 1'b0, "R8 drained", {7'd0, snap_valid_o}, 8'h00);

    // random phase, fixed seed
    void'($urandom(1234));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] f;
      f = 0;
      for (int b = 0; b < 8; b++) if ($urandom % 200 == 0) f[b] = 1'b1;
      fault_i      = f;
      inject_i     = ($urandom % 100 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      idle_i       = ($urandom % 50 != 0);
      mask_we_i    = ($urandom % 300 == 0);
      mask_wdata_i = 8'($urandom);
      st_begin_i   = ($urandom % 400 == 0);
      st_done_i    = ($urandom % 400 == 0);
      st_result_i  = ($urandom % 2) ? 8'hFF : 8'($urandom);
      snap_req_i   = ($urandom % 10 == 0);
      snap_ready_i = ($urandom % 3 == 0);
      step(1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule